// File: doc/BRIEF.md
# Masked Time Alarm Comparator

This block is the polled alarm unit of a real-time clock. It holds one threshold register for each of the seven calendar fields (seconds, minutes, hours, date, month, day of week, year) and one alarm configuration register. Each configuration bit enables the comparison of one live time field against its threshold. When every enabled field equals its threshold, a sticky alarm flag is set. Software polls the flag as bit 7 of the minutes register readback.

The flag has no dedicated clear bit. It drops when software reads or writes the configuration register or any threshold register. A clearing access made in the same cycle as a match takes priority, and the flag sets again on the next matching cycle. The time counters and the serial transport sit outside the block. The block sees the live fields as one packed input and serves a plain register bus with a registered read path.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the configuration register, every threshold register, the alarm flag and the read data are all 00h.
- R2: A write to address 0Eh+i (i = 0..6, field order seconds, minutes, hours, date, month, day, year) stores the byte as threshold i. A write to 15h stores configuration bits 6..0. A read of either returns the stored value on bus_rdata one cycle after the read strobe, and configuration bit 7 always reads back 0.
- R3: When configuration is non-zero and, for every bit i set in configuration bits 6..0, live field i equals threshold i, alarm_flag is 1 in the cycle after that condition holds. Bit 0 enables seconds, bit 1 minutes, bit 2 hours, bit 3 date, bit 4 month, bit 5 day and bit 6 year.
- R4: A field whose configuration bit is 0 does not prevent the alarm from setting, whatever its value.
- R5: With configuration 00h the alarm flag never sets, even when all fields equal their thresholds.
- R6: Once set, the alarm flag stays 1 after the match condition goes away, until a clearing access occurs.
- R7: A read or write of any address in 0Eh..15h makes alarm_flag 0 in the following cycle.
- R8: When a clearing access and a match occur in the same cycle, the flag is 0 in the next cycle. If the match still holds in a later cycle with no access, the flag sets again.
- R9: A read of address 00h+i (i = 0..6) returns live field i one cycle later. For the minutes address 01h, bit 7 is replaced by the alarm flag and bits 6..0 are live minutes. Unmapped addresses read 00h.
- R10: Reads of the time addresses 00h..06h and of unmapped addresses leave the alarm flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe for the current cycle |
| time_now | input | 56 | Live fields, byte i = field i (seconds in bits 7..0, year in bits 55..48) |
| bus_rdata | output | 8 | Read data, registered, holds between reads |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. Read data is captured at the edge where the strobe is sampled. The flag takes its set or clear decision at the edge where the match or the clearing access is present. The driver applies one bus and time stimulus at each falling edge and queues the expected outcome for that cycle. The monitor takes one item from the queue just after each following rising edge, so every comparison lands on the cycle in which the output is due. It never lands on the edge itself.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared sizes and address map of the alarm comparator.
// Assumes an 8-bit register bus and seven calendar fields.
package rtc_alarm_pkg;
    localparam int unsigned ALM_ADDR_W   = 6;
    localparam int unsigned ALM_DATA_W   = 8;
    localparam int unsigned ALM_NFIELD   = 7;
    localparam int unsigned ALM_THR_BASE = 'h0E;
    localparam int unsigned ALM_CFG_ADDR = 'h15;
    localparam int unsigned ALM_MIN_IDX  = 1;

    // Kind of bus cycle seen by the register file.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_kind_e;
endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm threshold and configuration storage.
// Decodes bus accesses to the alarm address space, stores thresholds and
// the configuration bits, and raises a clear pulse for any access to that
// space. Assumes a write takes precedence over a read in the same cycle.
module alarm_regfile #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NFIELD   = 7,
    parameter int unsigned THR_BASE = 'h0E,
    parameter int unsigned CFG_ADDR = 'h15
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [NFIELD-1:0][DATA_W-1:0]  thr_q,
    output logic [NFIELD-1:0]              cfg_q,
    output logic                           alarm_clr
);
    import rtc_alarm_pkg::*;

    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    logic [NFIELD-1:0] thr_hit;
    logic              cfg_hit;
    acc_kind_e         acc;

    // Classify the bus cycle.
    always_comb begin
        if (bus_wr)      acc = ACC_WRITE;
        else if (bus_rd) acc = ACC_READ;
        else             acc = ACC_NONE;
    end

    assign cfg_hit = (bus_addr == CFG_A);

    // One storage slot per threshold field.
    for (genvar i = 0; i < NFIELD; i++) begin : g_thr
        localparam logic [ADDR_W-1:0] THR_A = ADDR_W'(THR_BASE + i);
        assign thr_hit[i] = (bus_addr == THR_A);

        // Store threshold i on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q[i] <= '0;
            else if (acc == ACC_WRITE && thr_hit[i])
                thr_q[i] <= bus_wdata;
        end
    end

    // Store the enable bits; higher data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (acc == ACC_WRITE && cfg_hit)
            cfg_q <= bus_wdata[NFIELD-1:0];
    end

    // Any read or write of the alarm space clears the flag.
    assign alarm_clr = (acc != ACC_NONE) && (cfg_hit || (|thr_hit));
endmodule

// File: rtl/alarm_match.sv
// Module: masked field comparator.
// Each field passes when disabled or equal to its threshold; the match is
// the AND of all passes, gated by at least one enabled field. Purely
// combinational; assumes the live fields are stable within a cycle.
module alarm_match #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NFIELD = 7
) (
    input  logic [NFIELD-1:0][DATA_W-1:0] time_now,
    input  logic [NFIELD-1:0][DATA_W-1:0] thr_q,
    input  logic [NFIELD-1:0]             cfg_q,
    output logic                          match
);
    logic [NFIELD-1:0] field_ok;

    // Per-field pass term.
    for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
        assign field_ok[i] = !cfg_q[i] || (time_now[i] == thr_q[i]);
    end

    // A configuration of zero never matches.
    assign match = (|cfg_q) && (&field_ok);
endmodule

// File: rtl/alarm_flag.sv
// Module: sticky alarm flag.
// Sets on a match and holds until a clear pulse. The clear wins when both
// arrive in the same cycle.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr,
    output logic flag_q
);
    // Sticky set with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (clr)   flag_q <= 1'b0;
        else if (match) flag_q <= 1'b1;
    end
endmodule

// File: rtl/alarm_readback.sv
// Module: registered read data multiplexer.
// Serves the live time fields, the thresholds and the configuration. The
// alarm flag is placed in bit 7 of the minutes field. The output updates
// only on a read strobe and holds otherwise.
module alarm_readback #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NFIELD   = 7,
    parameter int unsigned THR_BASE = 'h0E,
    parameter int unsigned CFG_ADDR = 'h15,
    parameter int unsigned MIN_IDX  = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_rd,
    input  logic [NFIELD-1:0][DATA_W-1:0] time_now,
    input  logic [NFIELD-1:0][DATA_W-1:0] thr_q,
    input  logic [NFIELD-1:0]             cfg_q,
    input  logic                          flag_q,
    output logic [DATA_W-1:0]             bus_rdata
);
    logic [DATA_W-1:0] rd_next;

    // Select the byte addressed by the current read.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NFIELD; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                rd_next = time_now[i];
                if (i == MIN_IDX)
                    rd_next[DATA_W-1] = flag_q;
            end
            if (bus_addr == ADDR_W'(THR_BASE + i))
                rd_next = thr_q[i];
        end
        if (bus_addr == ADDR_W'(CFG_ADDR))
            rd_next = DATA_W'(cfg_q);
    end

    // Capture on a read strobe, hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Module: top of the masked time alarm comparator.
// Connects the register file, the comparator, the sticky flag and the
// read multiplexer. Assumes the live time fields come from a counter in
// the same clock domain.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W   = ALM_ADDR_W,
    parameter int unsigned DATA_W   = ALM_DATA_W,
    parameter int unsigned NFIELD   = ALM_NFIELD,
    parameter int unsigned THR_BASE = ALM_THR_BASE,
    parameter int unsigned CFG_ADDR = ALM_CFG_ADDR,
    parameter int unsigned MIN_IDX  = ALM_MIN_IDX
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          bus_rd,
    input  logic [NFIELD-1:0][DATA_W-1:0] time_now,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          alarm_flag
);
    logic [NFIELD-1:0][DATA_W-1:0] thr_q;
    logic [NFIELD-1:0]             cfg_q;
    logic                          alarm_clr;
    logic                          match;

    alarm_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NFIELD(NFIELD),
        .THR_BASE(THR_BASE), .CFG_ADDR(CFG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .thr_q(thr_q),
        .cfg_q(cfg_q), .alarm_clr(alarm_clr)
    );

    alarm_match #(.DATA_W(DATA_W), .NFIELD(NFIELD)) u_match (
        .time_now(time_now), .thr_q(thr_q), .cfg_q(cfg_q), .match(match)
    );

    alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .match(match), .clr(alarm_clr),
        .flag_q(alarm_flag)
    );

    alarm_readback #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NFIELD(NFIELD),
        .THR_BASE(THR_BASE), .CFG_ADDR(CFG_ADDR), .MIN_IDX(MIN_IDX)
    ) u_rdbk (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .time_now(time_now), .thr_q(thr_q), .cfg_q(cfg_q),
        .flag_q(alarm_flag), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Module: property checker for the alarm comparator, bound to the top.
// Observes the bus ports, the flag and the comparator output.
module rtc_alarm_match_chk #(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NFIELD   = 7,
    parameter int unsigned THR_BASE = 'h0E,
    parameter int unsigned CFG_ADDR = 'h15,
    parameter int unsigned MIN_IDX  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              alarm_flag,
    input logic [NFIELD-1:0] cfg_q,
    input logic              match
);
    logic in_space;
    logic access;

    assign in_space = (bus_addr >= ADDR_W'(THR_BASE)) &&
                      (bus_addr <= ADDR_W'(CFG_ADDR));
    assign access   = (bus_wr || bus_rd) && in_space;

    // R7: an access to the alarm space clears the flag.
    a_r7_clear_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !alarm_flag);

    // R6: the flag holds without a clearing access.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !access) |=> alarm_flag);

    // R3: a match with no access sets the flag.
    a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !access) |=> alarm_flag);

    // R5: a zero configuration never raises the flag.
    a_r5_zero_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0 && !alarm_flag) |=> !alarm_flag);

    // R9: the minutes readback carries the flag in its top bit.
    a_r9_min_bit7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(MIN_IDX)) |=>
            (bus_rdata[DATA_W-1] == $past(alarm_flag)));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NFIELD(NFIELD),
    .THR_BASE(THR_BASE), .CFG_ADDR(CFG_ADDR), .MIN_IDX(MIN_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .alarm_flag(alarm_flag),
    .cfg_q(cfg_q), .match(match)
);

// File: tb/sim_rtc_alarm_match.sv
`timescale 1ns/1ps
module sim_rtc_alarm_match;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [5:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic             bus_rd = 1'b0;
    logic [6:0][7:0]  time_now = '0;
    logic [6:0][7:0]  tnext = '0;
    logic [7:0]       bus_rdata;
    logic             alarm_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        bit         exp_flag;
        bit         chk_rd;
        logic [7:0] exp_rd;
    } item_t;
    item_t sb[$];

    rtc_alarm_match u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .time_now(time_now),
        .bus_rdata(bus_rdata), .alarm_flag(alarm_flag)
    );

    always #2.5 clk = ~clk;

    // Driver: one stimulus per falling edge, expected outcome queued.
    task automatic step(input logic [5:0] a, input bit w, input bit r,
                        input logic [7:0] d, input string req,
                        input bit ef, input bit crd, input logic [7:0] erd);
        item_t it;
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = w;
        bus_rd    = r;
        bus_wdata = d;
        time_now  = tnext;
        it.req = req; it.exp_flag = ef; it.chk_rd = crd; it.exp_rd = erd;
        sb.push_back(it);
    endtask

    // Monitor: compare just after the edge where each result is due.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (alarm_flag !== it.exp_flag) begin
                errors++;
                $display("FAIL %s alarm_flag actual %b expected %b",
                         it.req, alarm_flag, it.exp_flag);
            end
            if (it.chk_rd) begin
                checks++;
                if (bus_rdata !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s bus_rdata actual %h expected %h",
                             it.req, bus_rdata, it.exp_rd);
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5 / R1: all fields equal zero thresholds, cfg 00h, rdata 00h
        step(6'h00, 0, 0, 8'h00, "R5", 0, 1, 8'h00);
        step(6'h15, 0, 1, 8'h00, "R1", 0, 1, 8'h00);
        step(6'h0E, 0, 1, 8'h00, "R1", 0, 1, 8'h00);
        // R2: program seconds and minutes thresholds, read back
        step(6'h0E, 1, 0, 8'h30, "R2", 0, 0, 8'h00);
        step(6'h0F, 1, 0, 8'h45, "R2", 0, 0, 8'h00);
        step(6'h0F, 0, 1, 8'h00, "R2", 0, 1, 8'h45);
        step(6'h15, 1, 0, 8'h83, "R2", 0, 0, 8'h00);
        step(6'h15, 0, 1, 8'h00, "R2", 0, 1, 8'h03);
        // R3: minutes differ, no set
        tnext[0] = 8'h30; tnext[1] = 8'h44; tnext[2] = 8'h99;
        step(6'h00, 0, 0, 8'h00, "R3", 0, 0, 8'h00);
        // R3 / R4: both enabled match, hours disabled and different
        tnext[1] = 8'h45;
        step(6'h00, 0, 0, 8'h00, "R4", 1, 0, 8'h00);
        // R6: match gone, flag holds
        tnext[0] = 8'h31;
        step(6'h00, 0, 0, 8'h00, "R6", 1, 0, 8'h00);
        step(6'h00, 0, 0, 8'h00, "R6", 1, 0, 8'h00);
        // R9 / R10: minutes read carries the flag, time reads keep it
        step(6'h01, 0, 1, 8'h00, "R9", 1, 1, 8'hC5);
        step(6'h02, 0, 1, 8'h00, "R10", 1, 1, 8'h99);
        step(6'h20, 0, 1, 8'h00, "R10", 1, 1, 8'h00);
        // R7: read of hours threshold clears
        step(6'h10, 0, 1, 8'h00, "R7", 0, 1, 8'h00);
        tnext[0] = 8'h30;
        step(6'h00, 0, 0, 8'h00, "R3", 1, 0, 8'h00);
        // R8: clearing write during match wins, then sets again
        step(6'h14, 1, 0, 8'h00, "R8", 0, 0, 8'h00);
        step(6'h00, 0, 0, 8'h00, "R8", 1, 0, 8'h00);
        tnext[0] = 8'h31;
        step(6'h00, 0, 0, 8'h00, "R6", 1, 0, 8'h00);
        // R7: write to config clears
        step(6'h15, 1, 0, 8'h03, "R7", 0, 0, 8'h00);
        step(6'h01, 0, 1, 8'h00, "R9", 0, 1, 8'h45);
        // R3: hours enabled
        step(6'h10, 1, 0, 8'h12, "R3", 0, 0, 8'h00);
        step(6'h15, 1, 0, 8'h07, "R3", 0, 0, 8'h00);
        tnext[0] = 8'h30;
        step(6'h00, 0, 0, 8'h00, "R3", 0, 0, 8'h00);
        tnext[2] = 8'h12;
        step(6'h00, 0, 0, 8'h00, "R3", 1, 0, 8'h00);
        // R3 / R4: year only
        step(6'h15, 1, 0, 8'h40, "R7", 0, 0, 8'h00);
        step(6'h14, 1, 0, 8'h25, "R7", 0, 0, 8'h00);
        step(6'h00, 0, 0, 8'h00, "R3", 0, 0, 8'h00);
        tnext[6] = 8'h25; tnext[0] = 8'h00;
        step(6'h00, 0, 0, 8'h00, "R4", 1, 0, 8'h00);
        step(6'h00, 0, 0, 8'h00, "R6", 1, 0, 8'h00);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule